// File: doc/BRIEF.md
# Threefish-512 Rotating Subkey Generator

This block turns a 512-bit cipher key and a 128-bit tweak into the nineteen subkeys that one Threefish-512 block encryption consumes. It produces one subkey per step. When loaded, it derives a ninth key word and a third tweak word. It then keeps all key words in a nine-word ring register and all tweak words in a three-word ring register. Each step rotates both rings by one word. The words that feed the subkey therefore always sit in fixed positions, and no modulo-9 or modulo-3 selection multiplexers are needed.

Each subkey is formed combinationally from the ring heads and the step counter, so it is visible in the same cycle that the registers update. The round datapath can consume one subkey per clock. Control is a pair of plain strobes. A load captures the key and the tweak and restarts the sequence. An advance moves to the next subkey. The generator has no stream interface and applies no back-pressure. The consumer sees the current subkey and its index, and it decides when to pulse advance.

Top module: `tf512_subkey_gen`

## Requirements
- R1: While and after reset, before any load, `subkey_idx` is 0 and all 512 bits of `subkey` are zero.
- R2: A load forms the ninth key word as K0^K1^...^K7^64'h1BD11BDAA9FC1A22, and the third tweak word as T0^T1. Key word i is `key[64*i+63:64*i]`, T0 is `tweak[63:0]` and T1 is `tweak[127:64]`.
- R3: For index s, output word i (`subkey[64*i+63:64*i]`, i = 0..7) is key word (s+i) mod 9. Word 5 also adds tweak word s mod 3. Word 6 also adds tweak word (s+1) mod 3. Word 7 also adds s.
- R4: A load sets `subkey_idx` to 0 and presents subkey 0 in the cycle after the load edge. If load and advance are both high in the same cycle, the load wins.
- R5: An advance while the index is below 18 raises the index by one. The next subkey is visible in the cycle after that edge, so one subkey step takes one cycle.
- R6: An advance while the index is 18 is ignored: the index and the subkey stay unchanged until the next load.
- R7: With neither strobe high, the index and the subkey hold their values.
- R8: All additions in R3 wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture key and tweak, restart at subkey 0 |
| key | input | 512 | Eight 64-bit key words, word 0 in the low bits |
| tweak | input | 128 | Two 64-bit tweak words, word 0 in the low bits |
| advance | input | 1 | Step to the next subkey |
| subkey | output | 512 | Eight 64-bit words of the current subkey, word 0 in the low bits |
| subkey_idx | output | 5 | Index of the current subkey, 0 to 18 |

## Verification
The assertions check several properties on every cycle:
- the index never passes 18, steps by exactly one on an accepted advance, and returns to 0 after a load;
- the outputs hold when no strobe is active, or when an advance arrives at index 18;
- the rotation shows at the ports: word 0 after a step equals word 1 before it, and word 3 after a step equals word 4 before it;
- word 0 after a load equals the loaded key word 0.

Only the bench scenarios, which compare against an independent model, can show the exact value of the derived key word and tweak word, the tweak and index additions, and the wrap modulo 2^64 over the full nineteen-step walk.

// File: rtl/tf512_pkg.sv
package tf512_pkg;
  localparam int WORD_W    = 64;
  localparam int KEY_WORDS = 8;
  localparam int TW_WORDS  = 2;
  localparam int NUM_SUBK  = 19;
  localparam logic [WORD_W-1:0] KS_PARITY = 64'h1BD11BDAA9FC1A22;
endpackage

// File: rtl/tf512_keyext.sv
module tf512_keyext
  import tf512_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NK = KEY_WORDS,
  parameter int NT = TW_WORDS
) (
  input  logic [NK*W-1:0]     key_i,
  input  logic [NT*W-1:0]     tweak_i,
  output logic [(NK+1)*W-1:0] key_ext_o,
  output logic [(NT+1)*W-1:0] tw_ext_o
);
  logic [W-1:0] kpar, tpar;

  always_comb begin
    kpar = KS_PARITY[W-1:0];
    for (int i = 0; i < NK; i++) kpar = kpar ^ key_i[i*W +: W];
    tpar = '0;
    for (int j = 0; j < NT; j++) tpar = tpar ^ tweak_i[j*W +: W];
  end

  assign key_ext_o = {kpar, key_i};
  assign tw_ext_o  = {tpar, tweak_i};
endmodule

// File: rtl/tf512_word_ring.sv
module tf512_word_ring #(
  parameter int W    = 64,
  parameter int NW   = 9,
  parameter int NOUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [NW*W-1:0]  load_val_i,
  output logic [NOUT*W-1:0] head_o
);
  logic [NW*W-1:0] ring_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_q <= '0;
    else if (load_i)  ring_q <= load_val_i;
    else if (shift_i) ring_q <= {ring_q[W-1:0], ring_q[NW*W-1:W]};
  end

  assign head_o = ring_q[NOUT*W-1:0];
endmodule

// File: rtl/tf512_subkey_mix.sv
module tf512_subkey_mix #(
  parameter int W     = 64,
  parameter int NK    = 8,
  parameter int IDX_W = 5
) (
  input  logic [NK*W-1:0] kwords_i,
  input  logic [2*W-1:0]  twords_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NK*W-1:0] subkey_o
);
  localparam int TW_A  = NK - 3;
  localparam int TW_B  = NK - 2;
  localparam int CNT_W = NK - 1;

  for (genvar g = 0; g < NK; g++) begin : g_word
    if (g == TW_A) begin : g_ta
      assign subkey_o[g*W +: W] = kwords_i[g*W +: W] + twords_i[0 +: W];
    end else if (g == TW_B) begin : g_tb
      assign subkey_o[g*W +: W] = kwords_i[g*W +: W] + twords_i[W +: W];
    end else if (g == CNT_W) begin : g_cnt
      assign subkey_o[g*W +: W] = kwords_i[g*W +: W] + {{(W-IDX_W){1'b0}}, idx_i};
    end else begin : g_pass
      assign subkey_o[g*W +: W] = kwords_i[g*W +: W];
    end
  end
endmodule

// File: rtl/tf512_subkey_gen.sv
module tf512_subkey_gen
  import tf512_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int NK    = KEY_WORDS,
  parameter int NT    = TW_WORDS,
  parameter int NSUB  = NUM_SUBK,
  parameter int IDX_W = $clog2(NSUB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NK*W-1:0]   key,
  input  logic [NT*W-1:0]   tweak,
  input  logic              advance,
  output logic [NK*W-1:0]   subkey,
  output logic [IDX_W-1:0]  subkey_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSUB - 1);

  logic [(NK+1)*W-1:0] key_ext;
  logic [(NT+1)*W-1:0] tw_ext;
  logic [NK*W-1:0]     k_head;
  logic [2*W-1:0]      t_head;
  logic [IDX_W-1:0]    idx_q;
  logic                step_en;

  assign step_en = advance && !load && (idx_q != LAST_IDX);

  tf512_keyext #(.W(W), .NK(NK), .NT(NT)) keyext_i (
    .key_i(key), .tweak_i(tweak), .key_ext_o(key_ext), .tw_ext_o(tw_ext)
  );

  tf512_word_ring #(.W(W), .NW(NK+1), .NOUT(NK)) kring_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(step_en),
    .load_val_i(key_ext), .head_o(k_head)
  );

  tf512_word_ring #(.W(W), .NW(NT+1), .NOUT(2)) tring_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(step_en),
    .load_val_i(tw_ext), .head_o(t_head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (load)    idx_q <= '0;
    else if (step_en) idx_q <= idx_q + 1'b1;
  end

  tf512_subkey_mix #(.W(W), .NK(NK), .IDX_W(IDX_W)) mix_i (
    .kwords_i(k_head), .twords_i(t_head), .idx_i(idx_q), .subkey_o(subkey)
  );

  assign subkey_idx = idx_q;
endmodule

// File: rtl/tf512_subkey_chk.sv
module tf512_subkey_chk #(
  parameter int W     = 64,
  parameter int NK    = 8,
  parameter int NSUB  = 19,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             advance,
  input logic [W-1:0]     key_w0,
  input logic [NK*W-1:0]  subkey,
  input logic [IDX_W-1:0] subkey_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSUB - 1);

  // R4
  idx_clear_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> subkey_idx == '0);

  // R4
  word0_from_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> subkey[W-1:0] == $past(key_w0));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && subkey_idx < LAST) |=> subkey_idx == $past(subkey_idx) + 1'b1);

  // R5
  rotate_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && subkey_idx < LAST) |=> subkey[W-1:0] == $past(subkey[2*W-1:W]));

  // R5
  rotate_w3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && subkey_idx < LAST) |=> subkey[4*W-1:3*W] == $past(subkey[5*W-1:4*W]));

  // R6
  end_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && subkey_idx == LAST) |=> ($stable(subkey_idx) && $stable(subkey)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> ($stable(subkey_idx) && $stable(subkey)));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    subkey_idx <= LAST);
endmodule

bind tf512_subkey_gen tf512_subkey_chk #(.W(W), .NK(NK), .NSUB(NSUB), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
  .key_w0(key[W-1:0]), .subkey(subkey), .subkey_idx(subkey_idx)
);

// File: tb/tf512_subkey_gen_tb_top.sv
module tf512_subkey_gen_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         load = 0;
  logic         advance = 0;
  logic [511:0] key = '0;
  logic [127:0] tweak = '0;
  logic [511:0] subkey;
  logic [4:0]   subkey_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tf512_subkey_gen dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .key(key), .tweak(tweak),
    .advance(advance), .subkey(subkey), .subkey_idx(subkey_idx)
  );

  function automatic logic [511:0] model(input logic [511:0] k, input logic [127:0] t, input int s);
    logic [63:0] kw [9];
    logic [63:0] tw [3];
    logic [511:0] r;
    kw[8] = 64'h1BD11BDAA9FC1A22;
    for (int i = 0; i < 8; i++) begin
      kw[i] = k[64*i +: 64];
      kw[8] = kw[8] ^ kw[i];
    end
    tw[0] = t[63:0];
    tw[1] = t[127:64];
    tw[2] = tw[0] ^ tw[1];
    for (int i = 0; i < 8; i++) r[64*i +: 64] = kw[(s+i) % 9];
    r[5*64 +: 64] = r[5*64 +: 64] + tw[s % 3];
    r[6*64 +: 64] = r[6*64 +: 64] + tw[(s+1) % 3];
    r[7*64 +: 64] = r[7*64 +: 64] + 64'(s);
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] exp_sk, input int exp_idx);
    n_cmp++;
    if (subkey !== exp_sk || subkey_idx !== 5'(exp_idx)) begin
      n_bad++;
      $display("FAIL %s: idx=%0d sk=%h expected idx=%0d sk=%h", req, subkey_idx, subkey, exp_idx, exp_sk);
    end
  endtask

  task automatic pulse(input logic ld, input logic adv);
    @(negedge clk);
    load = ld;
    advance = adv;
    @(negedge clk);
    load = 0;
    advance = 0;
  endtask

  task automatic set_inputs(input logic [511:0] k, input logic [127:0] t);
    key = k;
    tweak = t;
  endtask

  task automatic t_reset;
    check("R1", '0, 0);
  endtask

  task automatic t_walk(input logic [511:0] k, input logic [127:0] t, input string req);
    set_inputs(k, t);
    pulse(1, 0);
    check(req, model(k, t, 0), 0);
    for (int s = 1; s < 19; s++) begin
      pulse(0, 1);
      check(req, model(k, t, s), s);
    end
  endtask

  task automatic t_saturate(input logic [511:0] k, input logic [127:0] t);
    pulse(0, 1);
    check("R6", model(k, t, 18), 18);
    pulse(0, 1);
    check("R6", model(k, t, 18), 18);
  endtask

  task automatic t_hold(input logic [511:0] k, input logic [127:0] t);
    set_inputs(k, t);
    pulse(1, 0);
    pulse(0, 1);
    pulse(0, 1);
    set_inputs(~k, ~t);
    repeat (3) @(negedge clk);
    check("R7", model(k, t, 2), 2);
  endtask

  task automatic t_priority(input logic [511:0] k, input logic [127:0] t);
    pulse(0, 1);
    set_inputs(k, t);
    pulse(1, 1);
    check("R4", model(k, t, 0), 0);
    pulse(0, 1);
    check("R4", model(k, t, 1), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_walk({8{64'h0123456789ABCDEF}} ^ {64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8},
           {64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978}, "R3");
    t_saturate({8{64'h0123456789ABCDEF}} ^ {64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8},
               {64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978});
    t_walk('0, '0, "R2");
    t_walk({8{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'hFFFF_FFFF_FFFF_FFF0}}, "R8");
    t_walk({64'hA5A5, 64'h5A5A, 64'h1, 64'h80000000_00000000, 64'h33, 64'h7, 64'hC0FFEE, 64'hBEEF},
           {64'h1234, 64'h8000_0000_0000_0001}, "R5");
    t_hold({8{64'h1111_2222_3333_4444}}, {64'h9, 64'h6});
    t_priority({8{64'h0F0F_0F0F_0F0F_0F0F}}, {64'hAAAA, 64'h5555});
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule